// File: doc/BRIEF.md
# Dual-Channel PCM Frame Transmitter

This block sends one serial transmit frame per sync pulse on a shared open-drain line. Each frame carries two companded voice samples. After each sample come four echo bits. They report that channel's power state and the three general-purpose latch outputs currently driven for it. Frames are clocked by a bit clock. A new frame starts on the bit-clock edge where the transmit sync is first seen high.

A channel that is powered down still has its slot. Its sample field becomes a fixed all-ones idle code, while its echo bits keep reporting the latched control values. When the global power-enable input is low, the line is released at once and any frame in progress is dropped. The pad is modelled as a data value plus a pull-low enable. A high level comes only from the external pull-up.

Top module: `pcm2_frame_tx`

## Requirements
- R1: While reset is asserted and after it is released (with no sync seen), `dout_oe` is 0 and `dout_d` is 1.
- R2: A frame starts at the rising `clk` edge where `xsync` is sampled 1 after being sampled 0 with `pdn` = 1. The first frame bit appears on `dout_d` right after that edge, and each later rising edge advances one bit.
- R3: The 24 driven bit times carry, in order: channel-1 sample MSB first, channel-1 power bit, channel-1 latch bits 2, 1, 0. Channel 2 follows in the same layout.
- R4: After the 24th bit time the line is released (`dout_oe` = 0, `dout_d` = 1). This covers the 4 empty bit times and every later bit time, until the next frame starts.
- R5: A channel whose power input (`pwr1`/`pwr2`) is 0 at frame start sends 8'hFF as its sample. Its power echo bit is 0, and its latch echo bits are still sent from `ctl1`/`ctl2`.
- R6: While `pdn` is 0, `dout_oe` is 0 in the same cycle. A frame in progress is abandoned, and a sync rising edge seen while `pdn` is 0 starts nothing.
- R7: `dout_oe` is 1 only during a driven bit time whose value is 0. `dout_d` then reads 0. A 1 bit releases the line.
- R8: Samples, power bits and latch values are captured at the frame-start edge. Changes after that edge do not alter the frame being sent.
- R9: A new rising edge of `xsync` in mid-frame restarts the frame. `xsync` held high for many cycles does not start further frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; bits launch on its rising edge |
| rst_n | input | 1 | Active-low reset |
| pdn | input | 1 | Global power enable, 0 = powered down |
| xsync | input | 1 | Transmit frame sync |
| pcm1 | input | 8 | Channel-1 companded sample |
| pcm2 | input | 8 | Channel-2 companded sample |
| pwr1 | input | 1 | Channel-1 power state (1 = on) |
| pwr2 | input | 1 | Channel-2 power state (1 = on) |
| ctl1 | input | 3 | Channel-1 latched general-purpose outputs |
| ctl2 | input | 3 | Channel-2 latched general-purpose outputs |
| dout_d | output | 1 | Current frame bit value, 1 when idle |
| dout_oe | output | 1 | Pull-low enable of the open-drain pad |

## Verification
The assertions assume that `xsync`, `pdn` and the sample and control inputs are synchronous to `clk` and stable around its rising edge. The bench meets this by changing every input only at the falling edge. The assertions also take the external pull-up as given, so they reason only about when the line is pulled low. The stimulus covers single-cycle and multi-cycle sync pulses, a sync held high, a sync that restarts a frame mid-way, and power-down both mid-frame and across a sync edge.

// File: rtl/pcm2_frame_tx.sv
module pcm2_frame_tx #(
  parameter int SAMPLE_W = 8,
  parameter int CTRL_W   = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pdn,
  input  logic                xsync,
  input  logic [SAMPLE_W-1:0] pcm1,
  input  logic [SAMPLE_W-1:0] pcm2,
  input  logic                pwr1,
  input  logic                pwr2,
  input  logic [CTRL_W-1:0]   ctl1,
  input  logic [CTRL_W-1:0]   ctl2,
  output logic                dout_d,
  output logic                dout_oe
);
  localparam int SLOT_W = SAMPLE_W + 1 + CTRL_W;
  localparam int WORD_W = 2 * SLOT_W;
  localparam int CNT_W  = $clog2(WORD_W + 1);

  logic              sync_q;
  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  left;
  logic              start, active;
  logic [SLOT_W-1:0] slot1, slot2;

  assign start  = pdn && xsync && !sync_q;
  assign active = (left != '0);
  assign slot1  = {pwr1 ? pcm1 : {SAMPLE_W{1'b1}}, pwr1, ctl1};
  assign slot2  = {pwr2 ? pcm2 : {SAMPLE_W{1'b1}}, pwr2, ctl2};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 1'b0;
    else        sync_q <= xsync;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '1;
      left  <= '0;
    end else if (!pdn) begin
      shreg <= '1;
      left  <= '0;
    end else if (start) begin
      shreg <= {slot1, slot2};
      left  <= CNT_W'(WORD_W);
    end else if (active) begin
      shreg <= {shreg[WORD_W-2:0], 1'b1};
      left  <= left - 1'b1;
    end
  end

  assign dout_d  = active ? shreg[WORD_W-1] : 1'b1;
  assign dout_oe = pdn && active && !shreg[WORD_W-1];

  a_r6_pdn_releases: assert property (@(posedge clk) disable iff (!rst_n)
    !pdn |-> !dout_oe);

  a_r7_pull_only_low: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe |-> !dout_d);

  a_r5_idle_msb: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !pwr1) |=> (dout_d && !dout_oe));

  a_r2_first_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (start && pwr1) |=> (dout_d == $past(pcm1[SAMPLE_W-1])));

  a_r4_tail_release: assert property (@(posedge clk) disable iff (!rst_n)
    (left == CNT_W'(1) && !start) |=> (!dout_oe && dout_d));
endmodule

// File: tb/pcm2_frame_tx_test.sv
module pcm2_frame_tx_test;
  localparam int CLK_P = 10;

  logic       clk = 1'b0, rst_n = 1'b0, pdn = 1'b0, xsync = 1'b0;
  logic [7:0] pcm1 = '0, pcm2 = '0;
  logic       pwr1 = 1'b0, pwr2 = 1'b0;
  logic [2:0] ctl1 = '0, ctl2 = '0;
  wire        dout_d, dout_oe;

  int    runs = 0, fails = 0, cyc = 0;
  string phase = "R1 reset state";
  bit    q[$];
  logic  prev_sync = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  pcm2_frame_tx uut (
    .clk(clk), .rst_n(rst_n), .pdn(pdn), .xsync(xsync),
    .pcm1(pcm1), .pcm2(pcm2), .pwr1(pwr1), .pwr2(pwr2),
    .ctl1(ctl1), .ctl2(ctl2), .dout_d(dout_d), .dout_oe(dout_oe));

  task automatic push_slot(input logic [7:0] s, input logic p, input logic [2:0] c);
    for (int i = 7; i >= 0; i--) q.push_back(p ? s[i] : 1'b1);
    q.push_back(p);
    for (int i = 2; i >= 0; i--) q.push_back(c[i]);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      prev_sync = 1'b0;
    end else begin
      if (!pdn) q.delete();
      else if (xsync && !prev_sync) begin
        q.delete();
        push_slot(pcm1, pwr1, ctl1);
        push_slot(pcm2, pwr2, ctl2);
      end else if (q.size() > 0) void'(q.pop_front());
      prev_sync = xsync;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (q.size() > 0) begin
      chk(phase, dout_d, q[0]);
      chk(phase, dout_oe, pdn & ~q[0]);
    end else begin
      chk(phase, dout_d, 1'b1);
      chk(phase, dout_oe, 1'b0);
    end
    chk("R7 pull only on zero", dout_oe & dout_d, 1'b0);
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic frame(input logic [7:0] a, input logic [7:0] b, input logic pa,
                       input logic pb, input logic [2:0] ca, input logic [2:0] cb,
                       input int width);
    pcm1 = a; pcm2 = b; pwr1 = pa; pwr2 = pb; ctl1 = ca; ctl2 = cb;
    xsync = 1'b1;
    steps(width);
    xsync = 1'b0;
  endtask

  initial begin
    steps(3);
    chk("R1 reset oe", dout_oe, 1'b0);
    chk("R1 reset d", dout_d, 1'b1);
    rst_n = 1'b1;
    steps(3);
    pdn = 1'b1;
    steps(2);

    phase = "R3 frame order";
    frame(8'hA5, 8'h3C, 1, 1, 3'b101, 3'b010, 1);
    steps(27);
    phase = "R4 tail released";
    steps(10);

    phase = "R2 wide sync start";
    frame(8'h00, 8'h81, 1, 1, 3'b111, 3'b001, 3);
    steps(30);

    phase = "R5 idle code ch1";
    frame(8'h12, 8'h00, 0, 1, 3'b011, 3'b100, 1);
    steps(30);
    phase = "R5 idle code both";
    frame(8'h00, 8'h00, 0, 0, 3'b000, 3'b110, 1);
    steps(30);

    phase = "R8 mid-frame input change";
    frame(8'h5A, 8'hC3, 1, 1, 3'b010, 3'b101, 1);
    pcm1 = 8'hFF; pcm2 = 8'h00; pwr1 = 0; pwr2 = 0; ctl1 = 3'b111; ctl2 = 3'b000;
    steps(30);

    phase = "R9 sync held high";
    frame(8'h69, 8'h96, 1, 1, 3'b001, 3'b100, 40);
    steps(5);
    phase = "R9 restart mid-frame";
    frame(8'h0F, 8'hF0, 1, 1, 3'b110, 3'b011, 1);
    steps(10);
    frame(8'h33, 8'hCC, 1, 1, 3'b100, 3'b001, 1);
    steps(30);

    phase = "R6 power-down mid-frame";
    frame(8'h00, 8'h00, 1, 1, 3'b000, 3'b000, 1);
    steps(6);
    pdn = 1'b0;
    step();
    chk("R6 released with pdn low", dout_oe, 1'b0);
    steps(4);
    phase = "R6 sync while powered down";
    frame(8'h00, 8'h11, 1, 1, 3'b000, 3'b000, 2);
    steps(5);
    xsync = 1'b1;
    steps(2);
    pdn = 1'b1;
    steps(30);
    chk("R6 no frame from stale sync", dout_oe, 1'b0);
    xsync = 1'b0;
    steps(2);
    phase = "R6 recovery frame";
    frame(8'h7E, 8'h24, 1, 0, 3'b101, 3'b111, 1);
    steps(30);

    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      runs++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end
endmodule